// File: doc/BRIEF.md
# Interrupt Presenter Thread Scanner

This block is the final stage of an interrupt delivery path. A routing stage hands it one notification request at a time. The request names a target by block and index, gives a format bit, an ignore flag and a logical server number. The engine first looks the target up in a small local table of target descriptors. Each descriptor is a single valid bit, written through a simple write port. If the lookup passes, the engine visits the hardware threads one per clock. For each thread it asks a context matcher whether that thread currently hosts the target, and on which privilege ring.

The scan always covers every thread, so a target found on two threads is detected and rejected rather than delivered twice. A thread that is turned off in the thread enable mask is skipped. Every request ends with one done pulse. The pulse carries a status code and, only when delivery succeeded, the winning thread and ring. A status of "not dispatched" marks the point where a later backlog or escalation stage would take over.

Top module: `irq_presenter_scan`

## Requirements
- R1: The target table holds ENTRIES valid bits, indexed by the target address {block, index}, with the block in the upper bits. All bits are cleared by reset. A write with `tbl_we` high stores `tbl_valid` at the addressed entry. A later request to that entry sees the new bit.
- R2: A request whose target address is ENTRIES or above ends with status 4 (missing). `done` rises one cycle after the accepting clock edge.
- R3: A request whose table entry is clear ends with status 3 (invalid) at the same one-cycle latency. No thread is visited.
- R4: When no enabled thread matches, status is 2 (not dispatched). `done` rises NTHREADS+1 cycles after acceptance.
- R5: When exactly one enabled thread matches, status is 1 (signalled), with `thr_id` set to that thread and `ring` set to the matching ring. `done` rises NTHREADS+1 cycles after acceptance.
- R6: With format 0, a thread matches on the physical ring (code 3) first, then the pool ring (code 2), then the OS ring (code 1). For each ring, its valid bit must be set and its CAM field must equal the target address.
- R7: If a second enabled thread matches, the scan stops at that thread k with status 5 (duplicate). `done` rises k+2 cycles after acceptance, and no thread is signalled.
- R8: A thread whose `thr_en` bit is 0 is never matched.
- R9: With format 1, a thread matches only on the user ring (code 0). Four conditions must all hold: the OS valid bit is set, the OS CAM equals the target address, the user valid bit is set, and the user server field equals `req_lserv`.
- R10: With format 0 and the ignore flag set, no thread matches.
- R11: Request handshake and done pulse:
  - `req_ready` is high only when the engine is idle, and a request is taken when both `req_valid` and `req_ready` are high.
  - `done` lasts exactly one cycle.
  - `thr_id` and `ring` are 0 unless status is 1.
- R12: Each thread's context is a 23-bit slice of `ctx_flat`; thread t uses bits [t*23 +: 23]. The fields, from the slice's MSB down, are:
  - physical valid (1 bit), physical CAM (5 bits)
  - pool valid (1 bit), pool CAM (5 bits)
  - OS valid (1 bit), OS CAM (5 bits)
  - user valid (1 bit), user server (4 bits)

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Notification request present |
| req_ready | output | 1 | Engine idle, request may be taken |
| req_fmt | input | 1 | Request format: 0 specific target, 1 user level |
| req_blk | input | 2 | Target block |
| req_idx | input | 3 | Target index within block |
| req_ign | input | 1 | Ignore flag (unsupported group form) |
| req_lserv | input | 4 | Logical server number for format 1 |
| thr_en | input | NTHREADS | Per-thread enable mask |
| ctx_flat | input | NTHREADS*23 | Packed thread contexts |
| tbl_we | input | 1 | Target table write strobe |
| tbl_blk | input | 2 | Table write block |
| tbl_idx | input | 3 | Table write index |
| tbl_valid | input | 1 | Valid bit to write |
| done | output | 1 | One-cycle outcome pulse |
| status | output | 3 | Outcome code |
| thr_id | output | $clog2(NTHREADS) | Signalled thread |
| ring | output | 2 | Signalled ring |

## Verification
Each ring is tried in isolation, so that a wrong ring code or a wrong thread number shows up on its own. Two targets are placed on the same thread to expose the ring order. Two threads are made to match at once; the early stop of a duplicate is told apart from a full scan by the latency. The same double match with one thread disabled shows that the mask acts before the duplicate test. Format 1 is run with a matching and with a mismatching server number, and format 0 with the ignore flag. Missing and invalid targets are checked through their short latency, which proves no thread was visited.

// File: rtl/pres_pkg.sv
package pres_pkg;
    localparam int BLK_W = 2;
    localparam int IDX_W = 3;
    localparam int LS_W  = 4;
    localparam int CAM_W = BLK_W + IDX_W;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_SIGNAL  = 3'd1,
        ST_NODISP  = 3'd2,
        ST_INVALID = 3'd3,
        ST_MISSING = 3'd4,
        ST_DUP     = 3'd5
    } status_e;

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;

    typedef enum logic [1:0] {
        S_IDLE, S_LOOKUP, S_SCAN, S_DONE
    } state_e;

    typedef struct packed {
        logic             phys_v;
        logic [CAM_W-1:0] phys_cam;
        logic             pool_v;
        logic [CAM_W-1:0] pool_cam;
        logic             os_v;
        logic [CAM_W-1:0] os_cam;
        logic             user_v;
        logic [LS_W-1:0]  user_ls;
    } ctx_t;

    localparam int CTX_W = $bits(ctx_t);

    typedef struct packed {
        logic             fmt;
        logic [CAM_W-1:0] cam;
        logic             ign;
        logic [LS_W-1:0]  lserv;
    } req_t;

    function automatic logic [CAM_W-1:0] make_cam(input logic [BLK_W-1:0] b,
                                                  input logic [IDX_W-1:0] i);
        return {b, i};
    endfunction
endpackage

// File: rtl/pres_tgt_table.sv
module pres_tgt_table
    import pres_pkg::*;
#(
    parameter int ENTRIES = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CAM_W-1:0] wr_addr,
    input  logic             wr_valid,
    input  logic [CAM_W-1:0] rd_addr,
    output logic             rd_present,
    output logic             rd_valid
);
    logic vbits [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) vbits[e] <= 1'b0;
        end else if (wr_en && (int'(wr_addr) < ENTRIES)) begin
            vbits[wr_addr] <= wr_valid;
        end
    end

    always_comb begin
        rd_present = int'(rd_addr) < ENTRIES;
        rd_valid   = rd_present ? vbits[rd_addr] : 1'b0;
    end
endmodule

// File: rtl/pres_ctx_match.sv
module pres_ctx_match
    import pres_pkg::*;
(
    input  ctx_t             ctx,
    input  logic             fmt,
    input  logic             ign,
    input  logic [CAM_W-1:0] cam,
    input  logic [LS_W-1:0]  lserv,
    output logic             hit,
    output logic [1:0]       ring
);
    always_comb begin
        hit  = 1'b0;
        ring = RING_USER;
        if (!fmt) begin
            if (!ign) begin
                if (ctx.phys_v && ctx.phys_cam == cam) begin
                    hit  = 1'b1;
                    ring = RING_PHYS;
                end else if (ctx.pool_v && ctx.pool_cam == cam) begin
                    hit  = 1'b1;
                    ring = RING_POOL;
                end else if (ctx.os_v && ctx.os_cam == cam) begin
                    hit  = 1'b1;
                    ring = RING_OS;
                end
            end
        end else if (ctx.os_v && ctx.os_cam == cam &&
                     ctx.user_v && ctx.user_ls == lserv) begin
            hit  = 1'b1;
            ring = RING_USER;
        end
    end
endmodule

// File: rtl/irq_presenter_scan.sv
module irq_presenter_scan
    import pres_pkg::*;
#(
    parameter int NTHREADS = 4,
    parameter int ENTRIES  = 24,
    localparam int TID_W   = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_fmt,
    input  logic [BLK_W-1:0]          req_blk,
    input  logic [IDX_W-1:0]          req_idx,
    input  logic                      req_ign,
    input  logic [LS_W-1:0]           req_lserv,
    input  logic [NTHREADS-1:0]       thr_en,
    input  logic [NTHREADS*CTX_W-1:0] ctx_flat,
    input  logic                      tbl_we,
    input  logic [BLK_W-1:0]          tbl_blk,
    input  logic [IDX_W-1:0]          tbl_idx,
    input  logic                      tbl_valid,
    output logic                      done,
    output logic [2:0]                status,
    output logic [TID_W-1:0]          thr_id,
    output logic [1:0]                ring
);
    localparam logic [TID_W-1:0] LAST = TID_W'(NTHREADS - 1);

    state_e           state;
    req_t             rq;
    logic [TID_W-1:0] cnt;
    logic             found_q;
    logic [TID_W-1:0] win_thr;
    logic [1:0]       win_ring;
    logic [2:0]       status_q;
    logic [TID_W-1:0] thr_q;
    logic [1:0]       ring_q;

    logic             t_present, t_valid;
    logic [NTHREADS-1:0] hits;
    logic [1:0]       rings [NTHREADS];
    logic             cur_hit;
    logic [1:0]       cur_ring;

    pres_tgt_table #(.ENTRIES(ENTRIES)) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tbl_we),
        .wr_addr    (make_cam(tbl_blk, tbl_idx)),
        .wr_valid   (tbl_valid),
        .rd_addr    (rq.cam),
        .rd_present (t_present),
        .rd_valid   (t_valid)
    );

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        pres_ctx_match u_match (
            .ctx   (ctx_t'(ctx_flat[t*CTX_W +: CTX_W])),
            .fmt   (rq.fmt),
            .ign   (rq.ign),
            .cam   (rq.cam),
            .lserv (rq.lserv),
            .hit   (hits[t]),
            .ring  (rings[t])
        );
    end

    assign cur_hit  = hits[cnt] & thr_en[cnt];
    assign cur_ring = rings[cnt];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            rq       <= '0;
            cnt      <= '0;
            found_q  <= 1'b0;
            win_thr  <= '0;
            win_ring <= '0;
            status_q <= ST_NONE;
            thr_q    <= '0;
            ring_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    rq.fmt   <= req_fmt;
                    rq.cam   <= make_cam(req_blk, req_idx);
                    rq.ign   <= req_ign;
                    rq.lserv <= req_lserv;
                    cnt      <= '0;
                    found_q  <= 1'b0;
                    state    <= S_LOOKUP;
                end
                S_LOOKUP: begin
                    thr_q  <= '0;
                    ring_q <= '0;
                    if (!t_present) begin
                        status_q <= ST_MISSING;
                        state    <= S_DONE;
                    end else if (!t_valid) begin
                        status_q <= ST_INVALID;
                        state    <= S_DONE;
                    end else begin
                        state <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (cur_hit && found_q) begin
                        status_q <= ST_DUP;
                        state    <= S_DONE;
                    end else begin
                        if (cur_hit) begin
                            found_q  <= 1'b1;
                            win_thr  <= cnt;
                            win_ring <= cur_ring;
                        end
                        if (cnt == LAST) begin
                            state <= S_DONE;
                            if (cur_hit) begin
                                status_q <= ST_SIGNAL;
                                thr_q    <= cnt;
                                ring_q   <= cur_ring;
                            end else if (found_q) begin
                                status_q <= ST_SIGNAL;
                                thr_q    <= win_thr;
                                ring_q   <= win_ring;
                            end else begin
                                status_q <= ST_NODISP;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign done      = (state == S_DONE);
    assign status    = status_q;
    assign thr_id    = thr_q;
    assign ring      = ring_q;
endmodule

// File: rtl/pres_scan_chk.sv
module pres_scan_chk #(
    parameter int NTHREADS = 4,
    parameter int TID_W    = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [NTHREADS-1:0] thr_en,
    input logic                done,
    input logic [2:0]          status,
    input logic [TID_W-1:0]    thr_id,
    input logic [1:0]          ring
);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_no_ready_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_ready);

    a_r8_signal_enabled_thread: assert property (@(posedge clk) disable iff (rst)
        (done && status == 3'd1) |-> thr_en[thr_id]);

    a_r7_zero_when_not_signalled: assert property (@(posedge clk) disable iff (rst)
        (done && status != 3'd1) |-> (thr_id == '0 && ring == 2'd0));

    a_r3_lookup_fail_latency: assert property (@(posedge clk) disable iff (rst)
        (done && (status == 3'd3 || status == 3'd4)) |-> $past(req_valid && req_ready, 2));

    a_r2_status_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> (status >= 3'd1 && status <= 3'd5));
endmodule

bind irq_presenter_scan pres_scan_chk #(.NTHREADS(NTHREADS), .TID_W(TID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .thr_en    (thr_en),
    .done      (done),
    .status    (status),
    .thr_id    (thr_id),
    .ring      (ring)
);

// File: tb/tb_irq_presenter_scan.sv
module tb_irq_presenter_scan;
    import pres_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 4;
    localparam int NENT = 24;
    localparam int TW   = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_fmt = 1'b0;
    logic [BLK_W-1:0] req_blk = '0;
    logic [IDX_W-1:0] req_idx = '0;
    logic req_ign = 1'b0;
    logic [LS_W-1:0] req_lserv = '0;
    logic [NT-1:0] thr_en = '1;
    logic [NT*CTX_W-1:0] ctx_flat;
    logic tbl_we = 1'b0;
    logic [BLK_W-1:0] tbl_blk = '0;
    logic [IDX_W-1:0] tbl_idx = '0;
    logic tbl_valid = 1'b0;
    logic done;
    logic [2:0] status;
    logic [TW-1:0] thr_id;
    logic [1:0] ring;

    ctx_t ctx [NT];
    logic shadow_v [NENT];

    always_comb
        for (int t = 0; t < NT; t++) ctx_flat[t*CTX_W +: CTX_W] = ctx[t];

    irq_presenter_scan #(.NTHREADS(NT), .ENTRIES(NENT)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [2:0] st;
        int         thr;
        int         rg;
        int         lat;
        int         acc;
        string      tag;
    } exp_t;

    exp_t sb [$];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Expected outcome derived from the requirements.
    function automatic exp_t model(input logic f, input logic [CAM_W-1:0] a,
                                   input logic ig, input logic [LS_W-1:0] ls);
        exp_t e;
        int nf;
        e.st = 3'd2; e.thr = 0; e.rg = 0; e.lat = NT + 1; nf = 0;
        if (int'(a) >= NENT) begin e.st = 3'd4; e.lat = 1; return e; end
        if (!shadow_v[a]) begin e.st = 3'd3; e.lat = 1; return e; end
        for (int t = 0; t < NT; t++) begin
            bit h; int r;
            h = 0; r = 0;
            if (!f && !ig) begin
                if (ctx[t].phys_v && ctx[t].phys_cam == a) begin h = 1; r = 3; end
                else if (ctx[t].pool_v && ctx[t].pool_cam == a) begin h = 1; r = 2; end
                else if (ctx[t].os_v && ctx[t].os_cam == a) begin h = 1; r = 1; end
            end else if (f && ctx[t].os_v && ctx[t].os_cam == a &&
                         ctx[t].user_v && ctx[t].user_ls == ls) begin
                h = 1; r = 0;
            end
            if (h && thr_en[t]) begin
                if (nf == 1) begin
                    e.st = 3'd5; e.thr = 0; e.rg = 0; e.lat = t + 2;
                    return e;
                end
                nf = 1; e.st = 3'd1; e.thr = t; e.rg = r;
            end
        end
        return e;
    endfunction

    task automatic tbl_write(input int a, input logic v);
        @(negedge clk);
        tbl_we = 1'b1; {tbl_blk, tbl_idx} = CAM_W'(a); tbl_valid = v;
        @(negedge clk);
        tbl_we = 1'b0;
        if (a < NENT) shadow_v[a] = v;
    endtask

    task automatic send(input logic f, input int a, input logic ig,
                        input int ls, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_fmt = f; {req_blk, req_idx} = CAM_W'(a); req_ign = ig;
        req_lserv = LS_W'(ls); req_valid = 1'b1;
        e = model(f, CAM_W'(a), ig, LS_W'(ls));
        @(negedge clk);
        req_valid = 1'b0;
        e.acc = cyc;
        e.tag = tag;
        sb.push_back(e);
        check(req_ready == 1'b0, "R11 ready low while busy", int'(req_ready), 0);
        while (!req_ready || sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop and compare on every done pulse.
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (prev_done)
                check(done == 1'b0, "R11 done one cycle", int'(done), 0);
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(status == e.st, {e.tag, " status"}, int'(status), int'(e.st));
                    check(int'(thr_id) == e.thr, {e.tag, " thread"}, int'(thr_id), e.thr);
                    check(int'(ring) == e.rg, {e.tag, " ring"}, int'(ring), e.rg);
                    check(cyc - e.acc == e.lat, {e.tag, " latency"}, cyc - e.acc, e.lat);
                end
            end
            prev_done = done;
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    localparam int A = 10;  // block 1, index 2
    localparam int B = 5;
    localparam int C = 20;

    initial begin
        for (int e = 0; e < NENT; e++) shadow_v[e] = 1'b0;
        for (int t = 0; t < NT; t++) ctx[t] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 reset ready", int'(req_ready), 1);
        check(done == 1'b0, "R11 reset done", int'(done), 0);

        send(0, 26, 0, 0, "R2 missing target");
        send(0, B, 0, 0, "R3 invalid target");
        send(0, A, 0, 0, "R1 reset cleared entry");

        tbl_write(A, 1); tbl_write(B, 1); tbl_write(C, 1);
        send(0, A, 0, 0, "R4 nobody dispatched");

        ctx[2].phys_v = 1; ctx[2].phys_cam = A;
        send(0, A, 0, 0, "R5 phys ring thread2");
        send(0, B, 0, 0, "R1 written entry B not dispatched");

        ctx[2] = '0;
        ctx[1].pool_v = 1; ctx[1].pool_cam = A;
        ctx[1].os_v = 1; ctx[1].os_cam = A;
        send(0, A, 0, 0, "R6 pool over os");
        ctx[1].phys_v = 1; ctx[1].phys_cam = A;
        send(0, A, 0, 0, "R6 phys over pool");
        ctx[1].phys_v = 0;
        ctx[1].pool_v = 0;
        send(0, A, 0, 0, "R6 os ring alone");

        ctx[0].os_v = 1; ctx[0].os_cam = A;
        send(0, A, 0, 0, "R7 duplicate stops at thread1");

        thr_en = 4'b1110;
        send(0, A, 0, 0, "R8 disabled thread skipped");
        thr_en = 4'b1111;

        ctx[3].os_v = 1; ctx[3].os_cam = C;
        ctx[3].user_v = 1; ctx[3].user_ls = 4'd7;
        send(1, C, 0, 7, "R9 user ring match");
        send(1, C, 0, 6, "R9 server mismatch");
        send(0, C, 0, 0, "R12 os field of thread3");

        send(0, A, 1, 0, "R10 ignore flag");

        tbl_write(A, 0);
        send(0, A, 0, 0, "R1 cleared entry invalid");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11 scoreboard drained", sb.size(), 0);
        finish_run();
    end
endmodule